// File: doc/BRIEF.md
# HDLC Serial Data Link Receiver

This block takes a serial HDLC data link one bit per transfer and turns it into bytes. It finds the flag pattern `0111 1110` and the abort pattern (seven 1s in a row). It removes the zeros that a transmitter stuffs in after five 1s. It writes each finished byte, least significant bit first on the wire, into a small circular message buffer. When the closing flag arrives it checks the CRC-16 frame check sequence. A 16-bit status word reports:

- the buffer index most recently written;
- sticky flags for idle flag seen, bad frame and abort seen;
- a receiver service interrupt.

Software watches the status word and drains the buffer through a separate byte read port. A read strobe on the status word clears the interrupt and the three sticky flags. A write strobe loads the control byte. Bit 7 of the control byte gates the interrupt onto the `dl_irq` pin.

The bit input is a valid/ready stream. `bit_rdy` is low during reset and rises on the first clock edge after reset is released. From then on it stays high, so the stream never sees back-pressure. A bit is consumed on every rising edge where `bit_vld` and `bit_rdy` are both high. `bit_vld` may be low for any number of cycles between bits.

Top module: `hdlc_link_rx`

## Requirements
- R1: A flag (`0`, six `1`s, `0`) that arrives with no data bit kept since the previous flag or abort sets the idle status bit (`reg_rdata[10]`). It does not raise the interrupt.
- R2: A seventh consecutive `1` sets the abort status bit (`reg_rdata[8]`) and discards the partial frame. That frame writes no further byte, and the next flag ends no frame. The bad-frame bit stays clear.
- R3: A `0` that follows five consecutive data `1`s is removed and is not data.
- R4: The frame check uses CRC-16 with polynomial x^16+x^12+x^5+1, preset to all ones, processed least significant bit first, with the complemented FCS sent low byte first. A closing flag whose residue is not 0xF0B8 sets the bad-frame bit (`reg_rdata[9]`).
- R5: A closing flag that arrives when the number of kept data bits is not a multiple of 8 sets the bad-frame bit.
- R6: Each finished byte is written at index (pointer + 1) mod 8, and the pointer then names that index. The pointer is `reg_rdata[13:11]` and resets to 7. `buf_rdata` returns the byte at `buf_addr`.
- R7: The interrupt bit (`reg_rdata[15]`) is set by every byte written and every frame closed. A `reg_rd` strobe clears the interrupt bit and bits 10:8 at that edge. An event on the same edge wins over the clear.
- R8: `dl_irq` is high exactly when the interrupt bit is set and control bit 7 is set. The control byte is loaded from `reg_wdata` on a `reg_wr` strobe and reads back on `reg_rdata[7:0]`.
- R9: `bit_rdy` is high from the first edge after reset. Idle cycles with `bit_vld` low do not change the decoded result.
- R10: After reset the status word reads 0x3800 and `dl_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Serial bit valid |
| bit_rdy | output | 1 | Serial bit ready |
| bit_dat | input | 1 | Serial line bit |
| reg_rd | input | 1 | Status read strobe, clears interrupt and sticky flags |
| reg_wr | input | 1 | Control write strobe |
| reg_wdata | input | 8 | Control byte, bit 7 enables `dl_irq` |
| reg_rdata | output | 16 | Status word (15 irq, 13:11 pointer, 10 idle, 9 bad, 8 abort, 7:0 control) |
| buf_addr | input | 3 | Message buffer read index |
| buf_rdata | output | 8 | Message buffer byte at `buf_addr` |
| dl_irq | output | 1 | Gated receiver interrupt pin |

## Verification
The sweep sends frames of every payload length that fits the buffer, from 0 to 6 bytes. One set uses arithmetic byte patterns. A second set uses 0xFF and 0x7E bytes, which force a stuffed zero in almost every byte and separate correct destuffing from bit slips. The same frames are then sent with an idle cycle after every bit, which shows that gaps in `bit_vld` do not disturb the result. Three single cases each isolate one way a frame fails: a corrupted FCS byte (bad frame from the CRC), a 12-bit body (bad frame from misalignment) and a run of seven 1s (abort without bad frame). Back-to-back flags with the enable bit both clear and set separate idle reporting from interrupt gating.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  // Data bits held back so a closing flag's own bits never reach a byte
  localparam int unsigned FLAG_LAG   = 6;
  localparam logic [2:0]  STUFF_RUN  = 3'd5;
  localparam logic [2:0]  FLAG_RUN   = 3'd6;
  localparam logic [2:0]  RUN_SAT    = 3'd7;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  typedef struct packed {
    logic vld;
    logic dat;
  } kept_bit_t;

  typedef struct packed {
    logic       irq;
    logic       idle;
    logic       bad;
    logic       abort;
  } rx_flags_t;
endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned LAG = FLAG_LAG
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc,
  input  logic      din,
  output kept_bit_t kept,
  output logic      flag_ev,
  output logic      abort_ev
);
  localparam int unsigned CW = $clog2(LAG + 1);

  logic [2:0]     ones_q;
  logic           active_q;
  logic [LAG-1:0] lag_q;
  logic [CW-1:0]  lag_cnt_q;
  logic           is_data;
  logic           lag_full;

  // Classify the incoming bit against the run of ones before it
  always_comb begin
    flag_ev  = acc && !din && (ones_q == FLAG_RUN);
    abort_ev = acc &&  din && (ones_q == FLAG_RUN);
    is_data  = acc && (din ? (ones_q < STUFF_RUN)
                           : ((ones_q != STUFF_RUN) && (ones_q != FLAG_RUN)));
    lag_full = (lag_cnt_q == CW'(LAG));
    kept.vld = is_data && active_q && lag_full;
    kept.dat = lag_q[LAG-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= '0;
      active_q  <= 1'b0;
      lag_q     <= '0;
      lag_cnt_q <= '0;
    end else if (acc) begin
      if (din) ones_q <= (ones_q == RUN_SAT) ? RUN_SAT : ones_q + 3'd1;
      else     ones_q <= '0;
      if (flag_ev) begin
        active_q  <= 1'b1;
        lag_cnt_q <= '0;
      end else if (abort_ev) begin
        active_q  <= 1'b0;
        lag_cnt_q <= '0;
      end else if (is_data && active_q) begin
        lag_q <= {lag_q[LAG-2:0], din};
        if (!lag_full) lag_cnt_q <= lag_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic dat,
  output logic good
);
  logic [15:0] crc_q;
  logic [15:0] crc_n;

  always_comb begin
    crc_n = {1'b0, crc_q[15:1]};
    if (crc_q[0] ^ dat) crc_n = crc_n ^ CRC_POLY_R;
    good = (crc_q == CRC_GOOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_PRESET;
    else if (clr)  crc_q <= CRC_PRESET;
    else if (upd)  crc_q <= crc_n;
  end
endmodule

// File: rtl/hdlc_rx_bytebuf.sv
module hdlc_rx_bytebuf #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          dat,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [PW-1:0] ptr,
  output logic          wr_pulse,
  output logic          aligned,
  output logic          any_bits
);
  logic [7:0]    shf_q;
  logic [2:0]    bcnt_q;
  logic          any_q;
  logic [PW-1:0] ptr_q;
  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    byte_n;
  logic [PW-1:0] wr_idx;

  always_comb begin
    byte_n   = {dat, shf_q[7:1]};
    wr_pulse = upd && (bcnt_q == 3'd7);
    wr_idx   = ptr_q + 1'b1;
    aligned  = (bcnt_q == 3'd0);
    any_bits = any_q;
    ptr      = ptr_q;
    rd_byte  = mem_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q  <= '0;
      bcnt_q <= '0;
      any_q  <= 1'b0;
      ptr_q  <= '1;
    end else if (clr) begin
      bcnt_q <= '0;
      any_q  <= 1'b0;
    end else if (upd) begin
      shf_q  <= byte_n;
      bcnt_q <= bcnt_q + 3'd1;
      any_q  <= 1'b1;
      if (wr_pulse) ptr_q <= wr_idx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (wr_pulse && (wr_idx == PW'(g)))
        mem_q[g] <= byte_n;
    end
  end
endmodule

// File: rtl/hdlc_link_rx.sv
module hdlc_link_rx
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 8,
  localparam int unsigned PW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  output logic          bit_rdy,
  input  logic          bit_dat,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic [PW-1:0] buf_addr,
  output logic [7:0]    buf_rdata,
  output logic          dl_irq
);
  logic          rdy_q;
  logic          acc;
  kept_bit_t     kept;
  logic          flag_ev;
  logic          abort_ev;
  logic          crc_good;
  logic          wr_pulse;
  logic          aligned;
  logic          any_bits;
  logic [PW-1:0] ptr;
  logic          frame_end;
  logic          boundary;
  rx_flags_t     flg_q;
  rx_flags_t     flg_set;
  logic [7:0]    ctrl_q;

  assign acc      = bit_vld && rdy_q;
  assign bit_rdy  = rdy_q;
  assign boundary = flag_ev || abort_ev;

  hdlc_rx_deframe #(.LAG(FLAG_LAG)) u_deframe (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .din      (bit_dat),
    .kept     (kept),
    .flag_ev  (flag_ev),
    .abort_ev (abort_ev)
  );

  hdlc_rx_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (boundary),
    .upd   (kept.vld),
    .dat   (kept.dat),
    .good  (crc_good)
  );

  hdlc_rx_bytebuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (boundary),
    .upd      (kept.vld),
    .dat      (kept.dat),
    .rd_idx   (buf_addr),
    .rd_byte  (buf_rdata),
    .ptr      (ptr),
    .wr_pulse (wr_pulse),
    .aligned  (aligned),
    .any_bits (any_bits)
  );

  always_comb begin
    frame_end     = flag_ev && any_bits;
    flg_set.irq   = wr_pulse || frame_end;
    flg_set.idle  = flag_ev && !any_bits;
    flg_set.bad   = frame_end && (!aligned || !crc_good);
    flg_set.abort = abort_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      flg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      flg_q <= flg_set | (reg_rd ? rx_flags_t'('0) : flg_q);
      if (reg_wr) ctrl_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata        = '0;
    reg_rdata[15]    = flg_q.irq;
    reg_rdata[13:11] = 3'(ptr);
    reg_rdata[10]    = flg_q.idle;
    reg_rdata[9]     = flg_q.bad;
    reg_rdata[8]     = flg_q.abort;
    reg_rdata[7:0]   = ctrl_q;
    dl_irq           = flg_q.irq && ctrl_q[7];
  end
endmodule

// File: rtl/hdlc_link_rx_chk.sv
module hdlc_link_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_acc,
  input logic       bit_dat,
  input logic       reg_rd,
  input logic       st_irq,
  input logic [2:0] st_ptr,
  input logic       st_idle,
  input logic       st_bad,
  input logic       st_abort,
  input logic       st_en,
  input logic       dl_irq
);
  // R8
  irq_pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_irq == (st_irq && st_en));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !bit_acc) |=> !st_irq && !st_idle && !st_bad && !st_abort);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_ptr) |-> (st_ptr == $past(st_ptr) + 3'd1));

  // R6
  ptr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_ptr) |-> $past(bit_acc));

  // R2
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_abort) |-> $past(bit_acc && bit_dat));

  // R1
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_idle) |-> $past(bit_acc && !bit_dat));

  // R4
  bad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_bad) |-> $past(bit_acc && !bit_dat));
endmodule

bind hdlc_link_rx hdlc_link_rx_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_acc  (bit_vld && bit_rdy),
  .bit_dat  (bit_dat),
  .reg_rd   (reg_rd),
  .st_irq   (reg_rdata[15]),
  .st_ptr   (reg_rdata[13:11]),
  .st_idle  (reg_rdata[10]),
  .st_bad   (reg_rdata[9]),
  .st_abort (reg_rdata[8]),
  .st_en    (reg_rdata[7]),
  .dl_irq   (dl_irq)
);

// File: tb/hdlc_link_rx_tb_top.sv
module hdlc_link_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0;
  logic        bit_rdy;
  logic        bit_dat = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  buf_addr = '0;
  logic [7:0]  buf_rdata;
  logic        dl_irq;

  int n_chk = 0;
  int n_fail = 0;
  int ones_run = 0;
  bit gap_mode = 1'b0;
  logic [7:0] pl [8];

  always #2 clk = ~clk;

  hdlc_link_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_rdy(bit_rdy),
    .bit_dat(bit_dat), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .dl_irq(dl_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_vld = 1'b1;
    bit_dat = b;
    @(negedge clk);
    bit_vld = 1'b0;
    if (gap_mode) @(negedge clk);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    ones_run = 0;
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin
        send_bit(1'b0);
        ones_run = 0;
      end
    end else ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic read_status(output logic [15:0] s);
    reg_rd = 1'b1;
    #1 s = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek_buf(input logic [2:0] a, output logic [7:0] d);
    buf_addr = a;
    #1 d = buf_rdata;
  endtask

  function automatic logic [15:0] crc_bytes(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ pl[j][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  // One framed message; checks status, pointer and buffer contents
  task automatic run_frame(input int n, input bit corrupt, input string tag);
    logic [15:0] s;
    logic [15:0] fcs;
    logic [2:0]  p0;
    logic [7:0]  d;
    logic [7:0]  exp_b;
    read_status(s);
    p0  = s[13:11];
    fcs = crc_bytes(n);
    send_flag();
    for (int j = 0; j < n; j++) send_byte(pl[j]);
    send_byte(fcs[7:0] ^ (corrupt ? 8'h01 : 8'h00));
    send_byte(fcs[15:8]);
    send_flag();
    read_status(s);
    chk({"R7 irq after frame ", tag}, 32'(s[15]), 32'd1);
    chk({"R4 bad bit ", tag}, 32'(s[9]), 32'(corrupt));
    chk({"R2 no abort ", tag}, 32'(s[8]), 32'd0);
    chk({"R6 pointer ", tag}, 32'(s[13:11]), 32'(3'(p0 + 3'(n + 2))));
    if (!corrupt)
      for (int j = 0; j < n + 2; j++) begin
        exp_b = (j < n) ? pl[j] : ((j == n) ? fcs[7:0] : fcs[15:8]);
        peek_buf(3'(p0 + 3'(j + 1)), d);
        chk({"R3 R6 buffer byte ", tag}, 32'(d), 32'(exp_b));
      end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] s;
    logic [2:0]  p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset status", 32'(reg_rdata), 32'h3800);
    chk("R10 reset irq pin", 32'(dl_irq), 32'd0);
    @(negedge clk);
    chk("R9 ready after reset", 32'(bit_rdy), 32'd1);

    // R1: back-to-back flags report idle and raise no interrupt
    send_flag();
    send_flag();
    read_status(s);
    chk("R1 idle set", 32'(s[10]), 32'd1);
    chk("R1 no irq on idle", 32'(s[15]), 32'd0);
    read_status(s);
    chk("R7 idle cleared by read", 32'(s[10]), 32'd0);

    // Sweep: arithmetic patterns, then stuffing-heavy patterns, then gaps (R9)
    for (int pass = 0; pass < 3; pass++) begin
      gap_mode = (pass == 2);
      for (int n = 0; n <= 6; n++) begin
        for (int j = 0; j < n; j++)
          pl[j] = (pass == 1) ? ((j % 2) ? 8'hFF : 8'h7E)
                              : 8'((n * 37 + j * 91 + 8'h5A) & 8'hFF);
        run_frame(n, 1'b0, $sformatf("pass%0d len%0d", pass, n));
      end
    end
    gap_mode = 1'b0;

    // R4: corrupted FCS
    for (int j = 0; j < 3; j++) pl[j] = 8'(j * 17 + 3);
    run_frame(3, 1'b1, "fcs error");

    // R5: 12-bit body closes misaligned
    read_status(s);
    p0 = s[13:11];
    send_flag();
    for (int i = 0; i < 12; i++) send_data_bit(1'b0);
    send_flag();
    read_status(s);
    chk("R5 misaligned bad", 32'(s[9]), 32'd1);
    chk("R5 one byte written", 32'(s[13:11]), 32'(3'(p0 + 3'd1)));

    // R2: abort mid-frame
    read_status(s);
    p0 = s[13:11];
    send_flag();
    send_byte(8'h55);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    read_status(s);
    chk("R2 abort set", 32'(s[8]), 32'd1);
    chk("R2 pointer unchanged", 32'(s[13:11]), 32'(p0));
    chk("R2 no bad on abort", 32'(s[9]), 32'd0);
    send_flag();
    read_status(s);
    chk("R2 flag after abort is idle", 32'(s[10]), 32'd1);
    chk("R2 flag after abort not bad", 32'(s[9]), 32'd0);
    chk("R2 pointer still unchanged", 32'(s[13:11]), 32'(p0));

    // R8: interrupt gating
    write_ctrl(8'h80);
    #1 chk("R8 enable reads back", 32'(reg_rdata[7:0]), 32'h80);
    pl[0] = 8'hA5;
    run_frame(1, 1'b0, "gated on");
    send_flag();
    send_byte(8'h3C);
    send_byte(8'hC3);
    #1 chk("R8 pin high when enabled", 32'(dl_irq), 32'd1);
    read_status(s);
    #1 chk("R8 pin low after read", 32'(dl_irq), 32'd0);
    write_ctrl(8'h00);
    send_byte(8'h11);
    #1 chk("R8 pin low when disabled", 32'(dl_irq), 32'd0);
    chk("R7 irq bit set when disabled", 32'(reg_rdata[15]), 32'd1);
    send_flag();

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule